// File: doc/BRIEF.md
# CPU Status Word and Interrupt Gate

This block keeps the processor status word. The word holds four fields: a global interrupt enable, a current priority level, a flag that marks a table-search terminator, and a flag that records an interrupted multiply or divide. The block also decides, in the same cycle, whether a pending interrupt request may preempt the running code.

On acceptance, the block does three things. It presents the pre-entry status word for the stack logic to save. It loads the new priority level and records whether a multiply or divide was in flight. A return-from-interrupt strobe restores the whole word from the stacked copy. When that restored copy carries the multiply/divide flag, the block tells the sequencer to resume the operation rather than restart it. The ALU reports each source operand so that the terminator flag follows the data. Software may also write the word, but any hardware event in the same cycle takes precedence.

Top module: `cpu_status_gate`

## Requirements
- R1: After reset `statusWord` is 0 (interrupts disabled, level 0, both flags clear) and `mdResume` is 0.
- R2: The status word layout is bits [3:0] current level, bit 4 enable, bit 5 end-of-table flag, bit 6 multiply/divide-pending flag. Bits [15:7] always read 0, whatever value is written or restored.
- R3: When `aluValid` is 1 and `aluSearchable` is 1, the end-of-table flag takes the following value at the next edge. It becomes 1 if the operand is the most negative number of its size and 0 otherwise. For a word (`aluByte`=0) the most negative number is 16'h8000. For a byte (`aluByte`=1) it is 8'h80 in bits [7:0], and the upper byte is ignored.
- R4: When `aluValid` is 1 and `aluSearchable` is 0, the end-of-table flag is cleared whatever the operand.
- R5: A request with `irqTrap`=0 is acknowledged (`irqAck`=1, combinationally, in the same cycle) only when the enable bit is 1 and `irqLevel` is strictly greater than the current level.
- R6: At current level 15 no request with `irqTrap`=0 is acknowledged. A request with `irqTrap`=1 is acknowledged whatever the enable bit and the level.
- R7: During an acknowledge cycle, `stackedStatus` equals the pre-entry status word. At the next edge the level takes `irqLevel`, the pending flag takes `mdBusy`, and the enable bit is unchanged.
- R8: A `retiStrobe` without an acknowledge in the same cycle loads the whole word from `retiStatus` (masked per R2) at the next edge. If both occur, the acknowledge wins and the restore is dropped.
- R9: `mdResume` is 1 for exactly the one cycle that follows a restore, and only if that restore left the pending flag set.
- R10: `swWrite` loads the word from `swData` (masked per R2) only when the same cycle has no acknowledge, no `retiStrobe` and no `aluValid`. Otherwise the write is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aluValid | input | 1 | ALU reports a source operand this cycle |
| aluOperand | input | 16 | Source operand value |
| aluByte | input | 1 | 1 = byte-sized operation, 0 = word |
| aluSearchable | input | 1 | Instruction can serve a table search |
| irqReq | input | 1 | Interrupt request pending |
| irqLevel | input | 4 | Priority level of the request |
| irqTrap | input | 1 | Request is a trap or non-maskable |
| mdBusy | input | 1 | Multiply/divide in progress |
| retiStrobe | input | 1 | Return-from-interrupt restore |
| retiStatus | input | 16 | Stacked status word to restore |
| swWrite | input | 1 | Software write enable |
| swData | input | 16 | Software write data |
| statusWord | output | 16 | Current status word |
| irqAck | output | 1 | Request accepted this cycle |
| stackedStatus | output | 16 | Pre-entry word to push, valid with irqAck |
| mdResume | output | 1 | Continue the interrupted multiply/divide |

## Verification
The bench sweeps every combination of enable bit, current level, request level and trap flag. A wrong comparison or a missed lockout therefore shows up as a wrong `irqAck` in the very cycle of the request, because that output is combinational. Faults in the register state show on `statusWord` one edge after the offending event. These include a mis-prioritized load, a leaked software write or a terminator test of the wrong width. The bench also covers a restore that fails to arm `mdResume`, or holds it high too long, which appears in the cycle after the restore.

// File: rtl/cpu_status_pkg.sv
package cpu_status_pkg;
  typedef struct packed {
    logic ackLoad;
    logic retiLoad;
    logic aluLoad;
    logic swLoad;
  } statusStrobes_t;
endpackage

// File: rtl/cpu_status_ctrl.sv
module cpu_status_ctrl
  import cpu_status_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             irqReq,
  input  logic             irqTrap,
  input  logic [LVL_W-1:0] irqLevel,
  input  logic [LVL_W-1:0] curLevel,
  input  logic             ienNow,
  input  logic             retiStrobe,
  input  logic             aluValid,
  input  logic             swWrite,
  output logic             irqAck,
  output statusStrobes_t   strb
);
  logic maskOk;

  // A maximum level can never be exceeded, so the lockout needs no extra term.
  assign maskOk = ienNow && (irqLevel > curLevel);
  assign irqAck = irqReq && (irqTrap || maskOk);

  always_comb begin
    strb.ackLoad  = irqAck;
    strb.retiLoad = retiStrobe && !irqAck;
    strb.aluLoad  = aluValid;
    strb.swLoad   = swWrite && !irqAck && !retiStrobe && !aluValid;
  end
endmodule

// File: rtl/cpu_status_dp.sv
module cpu_status_dp
  import cpu_status_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  statusStrobes_t    strb,
  input  logic [WORD_W-1:0] aluOperand,
  input  logic              aluByte,
  input  logic              aluSearchable,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic              mdBusy,
  input  logic [WORD_W-1:0] retiStatus,
  input  logic [WORD_W-1:0] swData,
  output logic [LVL_W-1:0]  curLevel,
  output logic              ienNow,
  output logic [WORD_W-1:0] statusWord,
  output logic              mdResume
);
  localparam int IEN_BIT = LVL_W;
  localparam int EOT_BIT = LVL_W + 1;
  localparam int MDP_BIT = LVL_W + 2;
  localparam int HALF_W  = WORD_W / 2;
  localparam logic [WORD_W-1:0] WORD_MIN = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [HALF_W-1:0] HALF_MIN = {1'b1, {(HALF_W-1){1'b0}}};

  logic eotFlag, mdPend, lastReti, eotCalc;

  always_comb begin
    if (!aluSearchable)
      eotCalc = 1'b0;
    else if (aluByte)
      eotCalc = (aluOperand[HALF_W-1:0] == HALF_MIN);
    else
      eotCalc = (aluOperand == WORD_MIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curLevel <= '0;
      ienNow   <= 1'b0;
      mdPend   <= 1'b0;
      eotFlag  <= 1'b0;
      lastReti <= 1'b0;
    end else begin
      lastReti <= strb.retiLoad;
      if (strb.ackLoad) begin
        curLevel <= irqLevel;
        mdPend   <= mdBusy;
      end else if (strb.retiLoad) begin
        curLevel <= retiStatus[LVL_W-1:0];
        ienNow   <= retiStatus[IEN_BIT];
        mdPend   <= retiStatus[MDP_BIT];
      end else if (strb.swLoad) begin
        curLevel <= swData[LVL_W-1:0];
        ienNow   <= swData[IEN_BIT];
        mdPend   <= swData[MDP_BIT];
      end
      if (strb.retiLoad)     eotFlag <= retiStatus[EOT_BIT];
      else if (strb.aluLoad) eotFlag <= eotCalc;
      else if (strb.swLoad)  eotFlag <= swData[EOT_BIT];
    end
  end

  always_comb begin
    statusWord                 = '0;
    statusWord[LVL_W-1:0]      = curLevel;
    statusWord[IEN_BIT]        = ienNow;
    statusWord[EOT_BIT]        = eotFlag;
    statusWord[MDP_BIT]        = mdPend;
  end

  assign mdResume = lastReti && mdPend;
endmodule

// File: rtl/cpu_status_gate.sv
module cpu_status_gate
  import cpu_status_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aluValid,
  input  logic [WORD_W-1:0] aluOperand,
  input  logic              aluByte,
  input  logic              aluSearchable,
  input  logic              irqReq,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic              irqTrap,
  input  logic              mdBusy,
  input  logic              retiStrobe,
  input  logic [WORD_W-1:0] retiStatus,
  input  logic              swWrite,
  input  logic [WORD_W-1:0] swData,
  output logic [WORD_W-1:0] statusWord,
  output logic              irqAck,
  output logic [WORD_W-1:0] stackedStatus,
  output logic              mdResume
);
  statusStrobes_t   strb;
  logic [LVL_W-1:0] curLevel;
  logic             ienNow;

  cpu_status_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .irqReq(irqReq), .irqTrap(irqTrap), .irqLevel(irqLevel),
    .curLevel(curLevel), .ienNow(ienNow), .retiStrobe(retiStrobe),
    .aluValid(aluValid), .swWrite(swWrite), .irqAck(irqAck), .strb(strb)
  );

  cpu_status_dp #(.WORD_W(WORD_W), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .aluOperand(aluOperand),
    .aluByte(aluByte), .aluSearchable(aluSearchable), .irqLevel(irqLevel),
    .mdBusy(mdBusy), .retiStatus(retiStatus), .swData(swData),
    .curLevel(curLevel), .ienNow(ienNow), .statusWord(statusWord),
    .mdResume(mdResume)
  );

  assign stackedStatus = statusWord;
endmodule

// File: rtl/cpu_status_gate_chk.sv
module cpu_status_gate_chk #(
  parameter int WORD_W = 16,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              aluValid,
  input logic              irqReq,
  input logic [LVL_W-1:0]  irqLevel,
  input logic              irqTrap,
  input logic              mdBusy,
  input logic              retiStrobe,
  input logic [WORD_W-1:0] retiStatus,
  input logic              swWrite,
  input logic [WORD_W-1:0] swData,
  input logic [WORD_W-1:0] statusWord,
  input logic              irqAck,
  input logic              mdResume
);
  localparam int IEN_BIT = LVL_W;
  localparam int MDP_BIT = LVL_W + 2;
  localparam int USED_W  = LVL_W + 3;
  localparam logic [WORD_W-1:0] USED_MASK = {{(WORD_W-USED_W){1'b0}}, {USED_W{1'b1}}};

  // R2
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord & ~USED_MASK) == '0);

  // R5
  maskable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !irqTrap) |-> (statusWord[IEN_BIT] && irqLevel > statusWord[LVL_W-1:0]));

  // R6
  top_level_lockout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[LVL_W-1:0] == {LVL_W{1'b1}} && !irqTrap) |-> !irqAck);

  // R7
  entry_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> (statusWord[LVL_W-1:0] == $past(irqLevel)) &&
               (statusWord[MDP_BIT] == $past(mdBusy)) &&
               (statusWord[IEN_BIT] == $past(statusWord[IEN_BIT])));

  // R8
  restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retiStrobe && !irqAck) |=> statusWord == ($past(retiStatus) & USED_MASK));

  // R9
  resume_after_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    mdResume |-> statusWord[MDP_BIT]);

  // R10
  sw_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swWrite && !irqAck && !retiStrobe && !aluValid) |=>
      statusWord == ($past(swData) & USED_MASK));
endmodule

bind cpu_status_gate cpu_status_gate_chk #(.WORD_W(WORD_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .aluValid(aluValid), .irqReq(irqReq),
  .irqLevel(irqLevel), .irqTrap(irqTrap), .mdBusy(mdBusy),
  .retiStrobe(retiStrobe), .retiStatus(retiStatus), .swWrite(swWrite),
  .swData(swData), .statusWord(statusWord), .irqAck(irqAck),
  .mdResume(mdResume)
);

// File: tb/cpu_status_gate_test.sv
`timescale 1ns/1ps
module cpu_status_gate_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        aluValid = 0, aluByte = 0, aluSearchable = 0;
  logic [15:0] aluOperand = 0;
  logic        irqReq = 0, irqTrap = 0, mdBusy = 0;
  logic [3:0]  irqLevel = 0;
  logic        retiStrobe = 0, swWrite = 0;
  logic [15:0] retiStatus = 0, swData = 0;
  logic [15:0] statusWord, stackedStatus;
  logic        irqAck, mdResume;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cpu_status_gate uut (
    .clk(clk), .rstN(rstN), .aluValid(aluValid), .aluOperand(aluOperand),
    .aluByte(aluByte), .aluSearchable(aluSearchable), .irqReq(irqReq),
    .irqLevel(irqLevel), .irqTrap(irqTrap), .mdBusy(mdBusy),
    .retiStrobe(retiStrobe), .retiStatus(retiStatus), .swWrite(swWrite),
    .swData(swData), .statusWord(statusWord), .irqAck(irqAck),
    .stackedStatus(stackedStatus), .mdResume(mdResume)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // software write: drive in low phase, takes effect at next edge
  task automatic swSet(logic [15:0] w);
    @(negedge clk); swWrite = 1; swData = w;
    @(negedge clk); swWrite = 0;
  endtask

  initial begin
    #(20.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    check("R1 status", statusWord, 16'h0000);
    check("R1 resume", {15'b0, mdResume}, 16'h0);

    // R2: upper bits masked on software write
    swSet(16'hFFFF);
    check("R2 mask", statusWord, 16'h007F);

    // R5 R6: exhaustive gate sweep
    for (int ien = 0; ien < 2; ien++) begin
      for (int lvl = 0; lvl < 16; lvl++) begin
        swSet(16'((ien << 4) | lvl));
        for (int il = 0; il < 16; il++) begin
          for (int tr = 0; tr < 2; tr++) begin
            @(negedge clk);
            irqReq = 1; irqLevel = 4'(il); irqTrap = tr[0];
            #1;
            check(tr ? "R6 trap ack" : (lvl == 15 ? "R6 lockout" : "R5 gate"),
                  {15'b0, irqAck},
                  {15'b0, (tr == 1) || (ien == 1 && il > lvl)});
            irqReq = 0; irqTrap = 0;
            #1;
          end
        end
      end
    end

    // R3 R4: terminator detection sweep
    begin
      logic [15:0] ops [8] = '{16'h8000, 16'h0080, 16'h8080, 16'hFF80,
                               16'h7FFF, 16'h0000, 16'hFFFF, 16'h807F};
      for (int s = 0; s < 2; s++) begin
        for (int b = 0; b < 2; b++) begin
          for (int k = 0; k < 8; k++) begin
            logic expE;
            expE = (s == 1) && (b == 1 ? ops[k][7:0] == 8'h80 : ops[k] == 16'h8000);
            @(negedge clk);
            aluValid = 1; aluOperand = ops[k]; aluByte = b[0]; aluSearchable = s[0];
            @(negedge clk);
            aluValid = 0;
            check(s ? "R3 eot" : "R4 eot clear", {15'b0, statusWord[5]}, {15'b0, expE});
          end
        end
      end
    end

    // R7: entry stacking and level load
    swSet(16'h0013);  // enable, level 3
    @(negedge clk);
    irqReq = 1; irqLevel = 4'd7; mdBusy = 1;
    #1;
    check("R7 ack", {15'b0, irqAck}, 16'h1);
    check("R7 stacked", stackedStatus, 16'h0013);
    @(negedge clk);
    irqReq = 0; mdBusy = 0;
    check("R7 entry word", statusWord, 16'h0057);

    // R9: restore with pending flag -> resume one cycle
    @(negedge clk);
    retiStrobe = 1; retiStatus = 16'hFF52;
    @(negedge clk);
    retiStrobe = 0;
    check("R8 restore", statusWord, 16'h0052);
    check("R9 resume high", {15'b0, mdResume}, 16'h1);
    @(negedge clk);
    check("R9 resume one cycle", {15'b0, mdResume}, 16'h0);

    // R9: restore without pending flag
    @(negedge clk);
    retiStrobe = 1; retiStatus = 16'h0014;
    @(negedge clk);
    retiStrobe = 0;
    check("R9 resume low", {15'b0, mdResume}, 16'h0);
    check("R8 restore 2", statusWord, 16'h0014);

    // R8: ack beats restore
    @(negedge clk);
    irqReq = 1; irqLevel = 4'd9; retiStrobe = 1; retiStatus = 16'h0002;
    @(negedge clk);
    irqReq = 0; retiStrobe = 0;
    check("R8 ack wins", statusWord, 16'h0019);

    // R10: software write ignored against alu, restore, ack
    @(negedge clk);
    swWrite = 1; swData = 16'h0045; aluValid = 1; aluSearchable = 1;
    aluByte = 0; aluOperand = 16'h8000;
    @(negedge clk);
    swWrite = 0; aluValid = 0;
    check("R10 vs alu", statusWord, 16'h0039);
    @(negedge clk);
    swWrite = 1; swData = 16'h0045; retiStrobe = 1; retiStatus = 16'h0011;
    @(negedge clk);
    swWrite = 0; retiStrobe = 0;
    check("R10 vs restore", statusWord, 16'h0011);
    @(negedge clk);
    swWrite = 1; swData = 16'h0045; irqReq = 1; irqLevel = 4'd4;
    @(negedge clk);
    swWrite = 0; irqReq = 0;
    check("R10 vs ack", statusWord, 16'h0014);
    swSet(16'h0062);
    check("R10 applied", statusWord, 16'h0062);

    finish();
  end
endmodule